// File: doc/BRIEF.md
# Outstanding Miss Tracker for a Non-Blocking Cache

This block keeps a record of every cache line that has missed and is still waiting for memory. A miss to a line that is not yet tracked takes a free entry and sends one memory request, tagged with the index of that entry. A later miss to a line already being tracked does not go to memory. It is queued behind the first miss in that entry's list of waiting requests. Because misses no longer block the pipeline, the cache can keep serving hits, and misses to other lines take entries of their own while earlier fetches are still in flight.

When memory returns a line, the matching entry stores it and passes it on through the cache fill output, so the data array can be updated. On the following cycles the entry sends out each waiting request on the completion stream, one per cycle, with its request ID and the word it asked for. The entry becomes free again only after its last waiting request has gone out. The number of entries and the number of waiting requests per entry are both parameters.

Top module: `mshr_file`

## Requirements
- R1: After synchronous reset every entry is free. `alloc_ready` is 1, and `mreq_valid`, `fill_valid` and `cmp_valid` are 0.
- R2: An accepted miss whose line matches no busy entry takes the lowest-numbered free entry. In the next cycle `mreq_valid` is 1 for exactly one cycle, with `mreq_line` equal to the line address and `mreq_tag` equal to that entry's index.
- R3: An accepted miss whose line matches a busy entry is added to that entry's waiting list, and `mreq_valid` stays 0 in the next cycle.
- R4: A miss to a line that no busy entry tracks takes a separate entry while other entries are still waiting for memory. At most one busy entry holds any given line.
- R5: `alloc_ready` is 0 in two cases: when every entry is busy and the line matches none of them, and when the line matches an entry whose waiting list already holds `N_SLOT` requests. A miss that matches an entry with room is accepted even when every entry is busy.
- R6: A refill whose line matches an entry that is waiting for memory produces, in the next cycle, a one-cycle `fill_valid` with the same line and data. A refill whose line matches no waiting entry is ignored: it produces no fill and no completion.
- R7: The waiting requests of a refilled entry complete one per cycle, in the order they were accepted. The first completion comes one cycle after `fill_valid`. `cmp_word` is bits `[o*WORD_W +: WORD_W]` of the refilled line, where `o` is the word offset the request carried. When several refilled entries have requests waiting, the lowest-numbered entry completes first.
- R8: An entry stays busy until its last waiting request has completed. It is free in the same cycle that this last completion is shown on the outputs. A later miss to the same line is then a new primary miss and sends a new memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | A miss is offered |
| alloc_line | input | LINE_AW | Line address of the miss |
| alloc_off | input | OFF_W | Word offset within the line |
| alloc_id | input | ID_W | Request ID returned on completion |
| alloc_ready | output | 1 | The miss can be accepted this cycle |
| mreq_valid | output | 1 | Memory request for a new line |
| mreq_line | output | LINE_AW | Line address to fetch |
| mreq_tag | output | TAG_W | Index of the entry that issued the request |
| refill_valid | input | 1 | Line data returned from memory |
| refill_line | input | LINE_AW | Address of the returned line |
| refill_data | input | LINE_W | Returned line, word 0 in the low bits |
| fill_valid | output | 1 | Write this line into the cache |
| fill_line | output | LINE_AW | Line address to write |
| fill_data | output | LINE_W | Line data to write |
| cmp_valid | output | 1 | A waiting request completes |
| cmp_id | output | ID_W | ID of the completing request |
| cmp_word | output | WORD_W | Requested word |

## Verification
The assertions check, on every cycle, the properties that do not depend on the scenario. A primary miss is always followed by exactly one memory request and a merged miss never is. No two busy entries hold the same line. A matching refill always produces a fill. No waiting list is pushed while full or popped while empty. The bench scenarios are needed for the rest. They show that completions come out in arrival order with the correct word slice. They show that ready returns in exactly the cycle the last waiting request leaves, that a refill for a line nobody is waiting on is dropped, and that a freed line starts a new fetch.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  // Life cycle of one tracking entry
  typedef enum logic [1:0] {
    ENT_FREE  = 2'd0,   // available for a primary miss
    ENT_WAIT  = 2'd1,   // memory request sent, line not yet back
    ENT_DRAIN = 2'd2    // line held, waiting requests being completed
  } ent_state_e;
endpackage

// File: rtl/mshr_first_set.sv
// Lowest-index set bit finder, used for free-entry, match and drain selection
module mshr_first_set #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/mshr_dep_fifo.sv
// Per-entry list of waiting requests, kept in arrival order
module mshr_dep_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  parameter int PW    = 2,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  assign head  = mem[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/mshr_file.sv
module mshr_file #(
  parameter int N_ENT   = 4,
  parameter int N_SLOT  = 4,
  parameter int LINE_AW = 20,
  parameter int OFF_W   = 2,
  parameter int WORD_W  = 16,
  parameter int ID_W    = 6,
  localparam int WORDS  = 1 << OFF_W,
  localparam int LINE_W = WORD_W * WORDS,
  localparam int TAG_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alloc_valid,
  input  logic [LINE_AW-1:0] alloc_line,
  input  logic [OFF_W-1:0]   alloc_off,
  input  logic [ID_W-1:0]    alloc_id,
  output logic               alloc_ready,
  output logic               mreq_valid,
  output logic [LINE_AW-1:0] mreq_line,
  output logic [TAG_W-1:0]   mreq_tag,
  input  logic               refill_valid,
  input  logic [LINE_AW-1:0] refill_line,
  input  logic [LINE_W-1:0]  refill_data,
  output logic               fill_valid,
  output logic [LINE_AW-1:0] fill_line,
  output logic [LINE_W-1:0]  fill_data,
  output logic               cmp_valid,
  output logic [ID_W-1:0]    cmp_id,
  output logic [WORD_W-1:0]  cmp_word
);
  import mshr_pkg::*;

  localparam int DEP_W = ID_W + OFF_W;
  localparam int SP_W  = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;
  localparam int SC_W  = $clog2(N_SLOT + 1);

  ent_state_e         ent_st   [N_ENT];
  logic [LINE_AW-1:0] ent_line [N_ENT];
  logic [LINE_W-1:0]  line_mem [N_ENT];

  logic [DEP_W-1:0]   dep_head [N_ENT];
  logic [SC_W-1:0]    dep_cnt  [N_ENT];
  logic [N_ENT-1:0]   dep_full, dep_empty;

  logic [N_ENT-1:0] free_vec, match_vec, drain_vec, rfl_vec;
  logic [N_ENT-1:0] push_vec, pop_vec;
  logic             free_any, hit_any, drain_any, rfl_any;
  logic [TAG_W-1:0] free_idx, hit_idx, drain_idx, rfl_idx;
  logic             alloc_fire;

  // entry classification
  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      free_vec[i]  = (ent_st[i] == ENT_FREE);
      match_vec[i] = (ent_st[i] != ENT_FREE) && (ent_line[i] == alloc_line);
      drain_vec[i] = (ent_st[i] == ENT_DRAIN) && !dep_empty[i];
      rfl_vec[i]   = refill_valid && (ent_st[i] == ENT_WAIT) &&
                     (ent_line[i] == refill_line);
    end
  end

  mshr_first_set #(.N(N_ENT), .IW(TAG_W)) u_free  (.vec(free_vec),  .any(free_any),  .idx(free_idx));
  mshr_first_set #(.N(N_ENT), .IW(TAG_W)) u_hit   (.vec(match_vec), .any(hit_any),   .idx(hit_idx));
  mshr_first_set #(.N(N_ENT), .IW(TAG_W)) u_drain (.vec(drain_vec), .any(drain_any), .idx(drain_idx));
  mshr_first_set #(.N(N_ENT), .IW(TAG_W)) u_rfl   (.vec(rfl_vec),   .any(rfl_any),   .idx(rfl_idx));

  assign alloc_ready = hit_any ? !dep_full[hit_idx] : free_any;
  assign alloc_fire  = alloc_valid && alloc_ready;

  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      push_vec[i] = alloc_fire && ((hit_any ? hit_idx : free_idx) == TAG_W'(i));
      pop_vec[i]  = drain_any && (drain_idx == TAG_W'(i));
    end
  end

  // waiting-request lists, one per entry
  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    mshr_dep_fifo #(.DEPTH(N_SLOT), .DW(DEP_W), .PW(SP_W), .CW(SC_W)) u_dep (
      .clk(clk), .rst(rst),
      .push(push_vec[g]), .push_data({alloc_id, alloc_off}),
      .pop(pop_vec[g]),
      .head(dep_head[g]), .count(dep_cnt[g]),
      .full(dep_full[g]), .empty(dep_empty[g])
    );
  end

  // entry state machine
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_ENT; i++) ent_st[i] <= ENT_FREE;
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        case (ent_st[i])
          ENT_FREE:  if (push_vec[i]) ent_st[i] <= ENT_WAIT;
          ENT_WAIT:  if (rfl_any && rfl_idx == TAG_W'(i)) ent_st[i] <= ENT_DRAIN;
          ENT_DRAIN: if (pop_vec[i] && !push_vec[i] && dep_cnt[i] == SC_W'(1))
                       ent_st[i] <= ENT_FREE;
          default:   ent_st[i] <= ENT_FREE;
        endcase
      end
    end
  end

  // line address capture on primary miss; line storage written on refill
  always_ff @(posedge clk) begin
    for (int i = 0; i < N_ENT; i++) begin
      if (push_vec[i] && free_vec[i]) ent_line[i] <= alloc_line;
    end
  end

  always_ff @(posedge clk) begin
    if (rfl_any) line_mem[rfl_idx] <= refill_data;
  end

  // registered outputs
  logic [OFF_W-1:0] head_off;
  logic [LINE_W-1:0] drain_line;
  assign head_off   = dep_head[drain_idx][OFF_W-1:0];
  assign drain_line = line_mem[drain_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      mreq_valid <= 1'b0;
      fill_valid <= 1'b0;
      cmp_valid  <= 1'b0;
    end else begin
      mreq_valid <= alloc_fire && !hit_any;
      fill_valid <= rfl_any;
      cmp_valid  <= drain_any;
    end
  end

  always_ff @(posedge clk) begin
    mreq_line <= alloc_line;
    mreq_tag  <= free_idx;
    fill_line <= refill_line;
    fill_data <= refill_data;
    cmp_id    <= dep_head[drain_idx][DEP_W-1:OFF_W];
    cmp_word  <= drain_line[head_off*WORD_W +: WORD_W];
  end

  assert_primary_request_R2: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && alloc_ready && !hit_any) |=> (mreq_valid && mreq_line == $past(alloc_line)));
  assert_merge_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && alloc_ready && hit_any) |=> !mreq_valid);
  assert_unique_line_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(match_vec) <= 1);
  assert_fill_follows_refill_R6: assert property (@(posedge clk) disable iff (rst)
    rfl_any |=> (fill_valid && fill_line == $past(refill_line)));
  assert_no_stray_fill_R6: assert property (@(posedge clk) disable iff (rst)
    !rfl_any |=> !fill_valid);
endmodule

// File: tb/sim_mshr_file.sv
module sim_mshr_file;
  localparam int LINE_AW = 20, OFF_W = 2, WORD_W = 16, ID_W = 6, LINE_W = 64, TAG_W = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic alloc_valid = 1'b0, refill_valid = 1'b0;
  logic [LINE_AW-1:0] alloc_line = '0, refill_line = '0;
  logic [OFF_W-1:0] alloc_off = '0;
  logic [ID_W-1:0] alloc_id = '0;
  logic [LINE_W-1:0] refill_data = '0;
  logic alloc_ready, mreq_valid, fill_valid, cmp_valid;
  logic [LINE_AW-1:0] mreq_line, fill_line;
  logic [TAG_W-1:0] mreq_tag;
  logic [LINE_W-1:0] fill_data;
  logic [ID_W-1:0] cmp_id;
  logic [WORD_W-1:0] cmp_word;

  mshr_file u0 (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [ID_W+WORD_W-1:0] sb [$];
  logic [ID_W-1:0]  m_id  [4][4];
  logic [OFF_W-1:0] m_off [4][4];
  int m_cnt [4] = '{0, 0, 0, 0};

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [LINE_W-1:0] line_data(input logic [LINE_AW-1:0] ln);
    return {ln[15:0] + 16'h3003, ln[15:0] + 16'h2002, ln[15:0] + 16'h1001, ln[15:0] ^ 16'h5A5A};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected below 20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // scoreboard monitor: every completion must match the head of the queue
  always @(negedge clk) begin
    if (!rst && cmp_valid) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R7 unexpected completion actual=%0h expected=none", {cmp_id, cmp_word});
      end else begin
        logic [ID_W+WORD_W-1:0] e;
        e = sb.pop_front();
        if ({cmp_id, cmp_word} !== e) begin
          fails++;
          $display("FAIL R7 completion actual=%0h expected=%0h", {cmp_id, cmp_word}, e);
        end
      end
    end
  end

  task automatic do_alloc(input logic [LINE_AW-1:0] ln, input logic [OFF_W-1:0] off,
                          input logic [ID_W-1:0] id, input bit primary, input int tag,
                          input string rq);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_line = ln; alloc_off = off; alloc_id = id;
    #1 chk({rq, " ready"}, 64'(alloc_ready), 64'd1);
    @(negedge clk);
    alloc_valid = 1'b0;
    chk({rq, " mreq_valid"}, 64'(mreq_valid), 64'(primary));
    if (primary) begin
      chk({rq, " mreq_line"}, 64'(mreq_line), 64'(ln));
      chk({rq, " mreq_tag"}, 64'(mreq_tag), 64'(tag));
    end
    m_id[tag][m_cnt[tag]] = id;
    m_off[tag][m_cnt[tag]] = off;
    m_cnt[tag]++;
  endtask

  task automatic probe(input logic [LINE_AW-1:0] ln, input bit exp, input string rq);
    @(negedge clk);
    alloc_valid = 1'b0; alloc_line = ln;
    #1 chk(rq, 64'(alloc_ready), 64'(exp));
  endtask

  task automatic queue_expect(input int tag, input logic [LINE_AW-1:0] ln);
    logic [LINE_W-1:0] d;
    d = line_data(ln);
    for (int k = 0; k < m_cnt[tag]; k++)
      sb.push_back({m_id[tag][k], d[m_off[tag][k]*WORD_W +: WORD_W]});
    m_cnt[tag] = 0;
  endtask

  task automatic do_refill(input logic [LINE_AW-1:0] ln, input int tag, input bit hit,
                           input string rq);
    @(negedge clk);
    refill_valid = 1'b1; refill_line = ln; refill_data = line_data(ln);
    if (hit) queue_expect(tag, ln);
    @(negedge clk);
    refill_valid = 1'b0;
    chk({rq, " fill_valid"}, 64'(fill_valid), 64'(hit));
    if (hit) begin
      chk({rq, " fill_line"}, 64'(fill_line), 64'(ln));
      chk({rq, " fill_data"}, fill_data, line_data(ln));
    end
    @(negedge clk);
    chk({hit ? "R7" : "R6", " first completion after fill"}, 64'(cmp_valid), 64'(hit));
  endtask

  localparam logic [LINE_AW-1:0] LA = 20'h00A10, LB = 20'h00B20, LC = 20'h00C30,
                                 LE = 20'h00E40, LF = 20'h00F50, LG = 20'h01060;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 ready after reset", 64'(alloc_ready), 64'd1);
    chk("R1 mreq idle", 64'(mreq_valid), 64'd0);
    chk("R1 fill idle", 64'(fill_valid), 64'd0);
    chk("R1 cmp idle", 64'(cmp_valid), 64'd0);

    do_alloc(LA, 2'd1, 6'd1, 1'b1, 0, "R2 primary");
    do_alloc(LA, 2'd3, 6'd2, 1'b0, 0, "R3 merge");
    do_alloc(LB, 2'd0, 6'd3, 1'b1, 1, "R4 second line");

    do_refill(LC, 0, 1'b0, "R6 ignored refill");
    do_refill(LA, 0, 1'b1, "R6 refill");
    repeat (3) @(negedge clk);

    do_alloc(LA, 2'd2, 6'd7, 1'b1, 0, "R8 realloc");
    do_alloc(LE, 2'd1, 6'd8, 1'b1, 2, "R4 third line");
    do_alloc(LF, 2'd3, 6'd9, 1'b1, 3, "R4 fourth line");
    probe(LG, 1'b0, "R5 all entries busy");
    do_alloc(LB, 2'd1, 6'd4, 1'b0, 1, "R5 merge while full");
    do_alloc(LB, 2'd2, 6'd5, 1'b0, 1, "R3 merge");
    do_alloc(LB, 2'd3, 6'd6, 1'b0, 1, "R3 merge");
    probe(LB, 1'b0, "R5 waiting list full");

    // refill B and watch the entry stay busy until its last completion
    @(negedge clk);
    refill_valid = 1'b1; refill_line = LB; refill_data = line_data(LB);
    queue_expect(1, LB);
    alloc_line = LG;
    @(negedge clk);
    refill_valid = 1'b0;
    chk("R6 fill for B", 64'(fill_valid), 64'd1);
    chk("R8 busy during drain", 64'(alloc_ready), 64'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R7 one completion per cycle", 64'(cmp_valid), 64'd1);
      chk("R8 frees with last completion", 64'(alloc_ready), 64'(k == 3));
    end

    do_alloc(LG, 2'd0, 6'd10, 1'b1, 1, "R8 freed entry reused");
    do_refill(LA, 0, 1'b1, "R6 refill");
    do_refill(LE, 2, 1'b1, "R6 refill");
    do_refill(LF, 3, 1'b1, "R6 refill");
    do_refill(LG, 1, 1'b1, "R6 refill");
    repeat (4) @(negedge clk);
    chk("R7 all waiting requests completed", 64'(sb.size()), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule